// File: doc/BRIEF.md
# One-Time Identification Register Unit

This unit holds a 128-bit identification value seen as eight 16-bit words. The low half is a factory number, set by a parameter, that no operation can alter. The high half starts blank (all ones). The user may program it by clearing bits, and then seal it for good with a lock bit. The unit sits beside a memory array and shares its address and data bus. A command byte written on the bus picks whether reads go to the array or to the identification words.

After reset the unit is in array mode. Every read then passes to the array, and the unit drives no data. The command 0x90 selects configuration reads. The command 0xFF returns to array mode. A program or lock takes two writes: first the setup byte 0xC0, then an address and a data word. The lock bit and the user words keep their values through reset. Only a power cycle restores their initial values.

Top module: `otp_id_unit`

## Requirements
- R1: After reset, the unit is in array mode and `errFlag` is 0.
- R2: In array mode, a read raises `arrayRdEn`, holds `cfgDrive` low and returns 0 on `rdData`.
- R3: A write whose low byte is 0x90 selects configuration mode. In that mode a read holds `arrayRdEn` low, raises `cfgDrive` and returns a word in the same cycle. Offset 0x81+k returns factory word k, where word k is bits 16k+15..16k of the factory value. Offset 0x85+k returns user word k.
- R4: A write of 0xFF selects array mode.
- R5: In array or configuration mode, a write whose low byte is not 0x90, 0xFF or 0xC0 leaves the mode unchanged.
- R6: A program write aimed at offsets 0x81–0x84 leaves the factory words unchanged and sets `errFlag`.
- R7: Writing 0xC0 and then data D at offset 0x85+k (k = 0..3), while the unit is unlocked, sets user word k to (old AND D). User words are all ones before their first program.
- R8: Writing 0xC0 and then any data at offset 0x80 sets the lock bit. A configuration read at 0x80 returns the lock bit in bit 1, with all other bits 0.
- R9: Once the lock bit is set, a program write at 0x85–0x88 leaves the word unchanged and sets `errFlag`.
- R10: Reset clears neither the lock bit nor the user words.
- R11: After the second write of a program or lock sequence, the unit is in configuration mode.
- R12: A configuration read at an offset outside 0x80–0x88 returns 0. The second write of a sequence at such an offset sets `errFlag`.
- R13: `errFlag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a command or program data |
| addr | input | 8 | Word offset for reads and writes |
| wrData | input | 16 | Write data; the low byte is the command |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Configuration read data, 0 when not driving |
| cfgDrive | output | 1 | Unit is driving `rdData` for this read |
| arrayRdEn | output | 1 | Read forwarded to the array |
| errFlag | output | 1 | Sticky refused-program flag |

## Verification
The hardest state to reach is a refused program when the refusal comes only from the lock bit. `errFlag` is usually already set by then, so such a refusal would not be visible. The stimulus therefore locks the user half and then applies reset, which clears the error flag but keeps the lock. It then tries to program an unlocked-looking user word. Only the lock can raise the flag at that point. The same reset also shows that the sealed data persists.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W    = 16;
  localparam int HALF_W    = 64;
  localparam int HALF_WORDS = HALF_W / WORD_W;
  localparam int SEL_W     = $clog2(HALF_WORDS);
  localparam int ADDR_W    = 8;

  localparam logic [ADDR_W-1:0] LOCK_OFS    = 8'h80;
  localparam logic [ADDR_W-1:0] FACTORY_OFS = 8'h81;
  localparam logic [ADDR_W-1:0] USER_OFS    = FACTORY_OFS + HALF_WORDS;

  localparam logic [7:0] CMD_CFG   = 8'h90;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_SETUP = 8'hC0;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_CFG   = 2'd1,
    MODE_SETUP = 2'd2
  } mode_t;

  typedef struct packed {
    logic progUser;
    logic setLock;
    logic [SEL_W-1:0] wordSel;
  } strobe_t;
endpackage

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter logic [HALF_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rdWord,
  output logic              isLocked
);
  // One-time cells: only a power cycle restores them
  logic              lockBit = 1'b0;
  logic [WORD_W-1:0] userWords [HALF_WORDS] = '{default: '1};
  logic [WORD_W-1:0] factWords [HALF_WORDS];

  genvar gi;
  generate
    for (gi = 0; gi < HALF_WORDS; gi++) begin : g_fact
      assign factWords[gi] = FACTORY_ID[gi*WORD_W +: WORD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.setLock) lockBit <= 1'b1;
    if (strb.progUser) userWords[strb.wordSel] <= userWords[strb.wordSel] & wrData;
  end

  always_comb begin
    rdWord = '0;
    if (addr == LOCK_OFS) rdWord[1] = lockBit;
    for (int k = 0; k < HALF_WORDS; k++) begin
      if (addr == FACTORY_OFS + ADDR_W'(k)) rdWord = factWords[k];
      if (addr == USER_OFS + ADDR_W'(k))    rdWord = userWords[k];
    end
  end

  assign isLocked = lockBit;
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              isLocked,
  output strobe_t           strb,
  output logic              cfgRead,
  output logic              arrayRdEn,
  output logic              errFlag
);
  mode_t mode, modeNext;
  logic  errSet;
  logic  inUser;
  logic [ADDR_W-1:0] userOfs;

  assign userOfs = addr - USER_OFS;
  assign inUser  = (addr >= USER_OFS) && (addr < USER_OFS + HALF_WORDS);

  always_comb begin
    modeNext      = mode;
    strb          = '0;
    strb.wordSel  = userOfs[SEL_W-1:0];
    errSet        = 1'b0;
    if (wrEn) begin
      if (mode == MODE_SETUP) begin
        modeNext = MODE_CFG;
        if (addr == LOCK_OFS)          strb.setLock  = 1'b1;
        else if (inUser && !isLocked)  strb.progUser = 1'b1;
        else                           errSet        = 1'b1;
      end else begin
        case (wrData[7:0])
          CMD_CFG:   modeNext = MODE_CFG;
          CMD_ARRAY: modeNext = MODE_ARRAY;
          CMD_SETUP: modeNext = MODE_SETUP;
          default:   modeNext = mode;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_ARRAY;
      errFlag <= 1'b0;
    end else begin
      mode <= modeNext;
      if (errSet) errFlag <= 1'b1;
    end
  end

  assign cfgRead   = rdEn && (mode == MODE_CFG);
  assign arrayRdEn = rdEn && (mode == MODE_ARRAY);
endmodule

// File: rtl/otp_id_unit.sv
module otp_id_unit
  import otp_pkg::*;
#(
  parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  addr,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  output logic        cfgDrive,
  output logic        arrayRdEn,
  output logic        errFlag
);
  strobe_t           strb;
  logic              isLocked;
  logic [WORD_W-1:0] rdWord;

  otp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .isLocked(isLocked), .strb(strb), .cfgRead(cfgDrive),
    .arrayRdEn(arrayRdEn), .errFlag(errFlag)
  );

  otp_store #(.FACTORY_ID(FACTORY_ID)) u_store (
    .clk(clk), .strb(strb), .wrData(wrData), .addr(addr),
    .rdWord(rdWord), .isLocked(isLocked)
  );

  assign rdData = cfgDrive ? rdWord : '0;
endmodule

// File: rtl/otp_id_chk.sv
module otp_id_chk #(
  parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [7:0]  addr,
  input logic [15:0] rdData,
  input logic        cfgDrive,
  input logic        arrayRdEn,
  input logic        errFlag,
  input logic        isLocked,
  input logic        progUser
);
  // R2
  exclusive_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDrive && arrayRdEn));
  // R2
  array_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrayRdEn || cfgDrive) |-> rdEn);
  // R6
  factory_word0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDrive && addr == 8'h81) |-> rdData == FACTORY_ID[15:0]);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(isLocked));
  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(errFlag));
  // R9
  locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(progUser && isLocked));
endmodule

bind otp_id_unit otp_id_chk #(.FACTORY_ID(FACTORY_ID)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData),
  .cfgDrive(cfgDrive), .arrayRdEn(arrayRdEn), .errFlag(errFlag),
  .isLocked(isLocked), .progUser(strb.progUser)
);

// File: tb/sim_otp_id_unit.sv
module sim_otp_id_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_W = 2'd0, OP_RC = 2'd1, OP_RA = 2'd2;
  localparam int NV = 29;
  // {op, addr, data, expected read, expected errFlag}
  localparam logic [42:0] VEC [NV] = '{
    {OP_RA, 8'h81, 16'h0000, 16'h0000, 1'b0},  // R2
    {OP_W,  8'h00, 16'h0090, 16'h0000, 1'b0},  // R3
    {OP_RC, 8'h81, 16'h0000, 16'hCDEF, 1'b0},  // R3
    {OP_RC, 8'h84, 16'h0000, 16'h0123, 1'b0},  // R3
    {OP_RC, 8'h85, 16'h0000, 16'hFFFF, 1'b0},  // R7 blank
    {OP_RC, 8'h80, 16'h0000, 16'h0000, 1'b0},  // R8 unlocked
    {OP_RC, 8'h8A, 16'h0000, 16'h0000, 1'b0},  // R12
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b0},
    {OP_W,  8'h85, 16'h1234, 16'h0000, 1'b0},
    {OP_RC, 8'h85, 16'h0000, 16'h1234, 1'b0},  // R7 R11
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b0},
    {OP_W,  8'h85, 16'hFF00, 16'h0000, 1'b0},
    {OP_RC, 8'h85, 16'h0000, 16'h1200, 1'b0},  // R7 AND
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b0},
    {OP_W,  8'h82, 16'h0000, 16'h0000, 1'b0},
    {OP_RC, 8'h82, 16'h0000, 16'h89AB, 1'b1},  // R6
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b1},
    {OP_W,  8'h88, 16'hA5A5, 16'h0000, 1'b1},
    {OP_RC, 8'h88, 16'h0000, 16'hA5A5, 1'b1},  // R7 R13
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b1},
    {OP_W,  8'h80, 16'h0000, 16'h0000, 1'b1},
    {OP_RC, 8'h80, 16'h0000, 16'h0002, 1'b1},  // R8
    {OP_W,  8'h00, 16'h00C0, 16'h0000, 1'b1},
    {OP_W,  8'h86, 16'h0000, 16'h0000, 1'b1},
    {OP_RC, 8'h86, 16'h0000, 16'hFFFF, 1'b1},  // R9
    {OP_W,  8'h00, 16'h00FF, 16'h0000, 1'b1},
    {OP_RA, 8'h85, 16'h0000, 16'h0000, 1'b1},  // R4
    {OP_W,  8'h00, 16'h0055, 16'h0000, 1'b1},
    {OP_RA, 8'h86, 16'h0000, 16'h0000, 1'b1}   // R5
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic cfgDrive, arrayRdEn, errFlag;
  int checks = 0, fails = 0;

  otp_id_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .cfgDrive(cfgDrive),
    .arrayRdEn(arrayRdEn), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input string tag, input logic cfg, input logic [7:0] a,
                        input logic [15:0] expD, input logic expE);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a;
    #1;
    checks++;
    if (rdData !== expD || cfgDrive !== cfg || arrayRdEn !== !cfg || errFlag !== expE) begin
      fails++;
      $display("FAIL %s addr=%h: data=%h drive=%b arr=%b err=%b, expected data=%h drive=%b arr=%b err=%b",
               tag, a, rdData, cfgDrive, arrayRdEn, errFlag, expD, cfg, !cfg, expE);
    end
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doRead("R1", 1'b0, 8'h81, 16'h0000, 1'b0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42:41] == OP_W) doWrite(VEC[i][40:33], VEC[i][32:17]);
      else doRead($sformatf("vec%0d R2-R9", i), VEC[i][42:41] == OP_RC,
                  VEC[i][40:33], VEC[i][16:1], VEC[i][0]);
    end
    // R10: reset keeps lock and user data; R1: error cleared, array mode
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    doRead("R1 after reset", 1'b0, 8'h80, 16'h0000, 1'b0);
    doWrite(8'h00, 16'h0090);
    doRead("R10 lock kept", 1'b1, 8'h80, 16'h0002, 1'b0);
    doRead("R10 user kept", 1'b1, 8'h85, 16'h1200, 1'b0);
    // R9: refusal caused only by the lock
    doWrite(8'h00, 16'h00C0);
    doWrite(8'h87, 16'h0000);
    doRead("R9 locked refuse", 1'b1, 8'h87, 16'hFFFF, 1'b1);
    // R12: sequence at unmapped offset
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    doWrite(8'h00, 16'h00C0);
    doWrite(8'h99, 16'h0000);
    doRead("R12 unmapped err / R11 mode", 1'b1, 8'h99, 16'h0000, 1'b1);
    // R5 in config mode
    doWrite(8'h00, 16'h0012);
    doRead("R5 cfg kept", 1'b1, 8'h84, 16'h0123, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule